// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block collects eight interrupt request lines, ranks them by fixed priority and hands the winning line's vector to a processor through a two-pulse acknowledge handshake. Software reaches it through two byte-wide addresses. One is a command address, used for initialization, end-of-interrupt commands and selecting what a command read returns. The other is a data address, used for the line mask and the initialization payload bytes.

After reset all lines are masked. Software programs a vector base with a short initialization sequence, unmasks the lines it services and then answers each interrupt by acknowledging it and retiring it. An interrupt is retired either by an explicit end-of-interrupt command or automatically, when automatic retirement was chosen at initialization. A request that disappears before it is acknowledged still completes the handshake and yields the lowest-priority line's vector without marking that line in service.

The byte width and the line count are the same parameter, because the mask, request and in-service registers are read back as one byte each.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the request and in-service registers read 0x00, command reads return the request register, and `int_out` and `vec_valid` are low.
- R2: Outside initialization, a write to the data address (addr=1) loads the mask, where bit n = 1 blocks line n. A read of the data address returns the mask on `bus_rdata` one cycle after `bus_rd`.
- R3: A command write (addr=0) with bit 4 set starts initialization and clears the request and in-service registers. The following data writes are taken as the base byte, then a cascade byte (skipped when bit 1 of the start byte is set), then a mode byte (taken only when bit 0 of the start byte is set). Initialization leaves the mask unchanged.
- R4: The acknowledge handshake is two single-cycle `ack` pulses. In the cycle after the second pulse, `vec_valid` is high for one cycle and `vec_out` equals base + line.
- R5: A rising edge on a line sets its request bit. The bit stays set while the line stays high, and clears when the line drops or when the first acknowledge pulse grants that line.
- R6: Line 0 has the highest priority. The first acknowledge pulse grants the lowest-numbered unmasked pending line and sets its in-service bit. `int_out` is high only when such a line outranks every in-service bit.
- R7: A masked line still sets its request bit but never raises `int_out`.
- R8: Command byte 0x0A selects the request register for command reads and 0x0B selects the in-service register. The selection holds until it is changed.
- R9: Command byte 0x60+L (L = 0..7) clears in-service bit L only.
- R10: Command byte 0x20 clears the highest-priority set in-service bit.
- R11: When bit 1 of the mode byte is set, the granted in-service bit clears at the second acknowledge pulse.
- R12: If no line is eligible at the first acknowledge pulse, the vector is base + 7 and no in-service bit is set, even when line 7 is masked.
- R13: An end-of-interrupt command written in the same cycle as the first acknowledge pulse takes effect, and the grant made by that pulse also takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | 0 = command address, 1 = data address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | Acknowledge pulse |
| vec_out | output | 8 | Vector byte |
| vec_valid | output | 1 | Vector strobe |

## Verification
Two functions can act on the in-service register in the same cycle: a retirement command and a grant made by the first acknowledge pulse. The bench provokes this with line 5 already in service and line 3 pending. It writes the specific end-of-interrupt for line 5 in the very cycle of the first acknowledge pulse for line 3. The in-service register is then read back and must show line 3 alone, which proves that neither update was lost. A non-specific retirement then has to empty the register.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {CFG_RUN, CFG_BASE, CFG_CASC, CFG_MODE} cfg_state_t;
  localparam logic [2:0] OP_EOI_ANY  = 3'b001;
  localparam logic [2:0] OP_EOI_LINE = 3'b011;
  localparam int START_BIT = 4;
  localparam int OCW3_BIT  = 3;
  localparam int NO_CASC_BIT = 1;
  localparam int HAS_MODE_BIT = 0;
  localparam int AUTO_BIT = 1;
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_regif.sv
module pic_regif
  import pic_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [N-1:0]  wdata,
  input  logic [N-1:0]  irr,
  input  logic [N-1:0]  isr,
  output logic [N-1:0]  rdata,
  output logic [N-1:0]  mask,
  output logic [N-1:0]  base,
  output logic          aeoi,
  output logic          init_pulse,
  output logic          eoi_line_v,
  output logic [IW-1:0] eoi_line,
  output logic          eoi_any_v
);
  cfg_state_t state;
  logic       want_casc, want_mode, show_isr;
  logic       cmd_wr, dat_wr;

  assign cmd_wr = wr_en && !addr;
  assign dat_wr = wr_en && addr;

  always_comb begin
    init_pulse = cmd_wr && wdata[START_BIT];
    eoi_line_v = 1'b0;
    eoi_any_v  = 1'b0;
    eoi_line   = wdata[IW-1:0];
    if (cmd_wr && !wdata[START_BIT] && !wdata[OCW3_BIT]) begin
      eoi_line_v = (wdata[N-1:N-3] == OP_EOI_LINE);
      eoi_any_v  = (wdata[N-1:N-3] == OP_EOI_ANY);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= CFG_RUN;
      want_casc <= 1'b0;
      want_mode <= 1'b0;
      show_isr  <= 1'b0;
      mask      <= '1;
      base      <= '0;
      aeoi      <= 1'b0;
    end else if (init_pulse) begin
      state     <= CFG_BASE;
      want_casc <= !wdata[NO_CASC_BIT];
      want_mode <= wdata[HAS_MODE_BIT];
      show_isr  <= 1'b0;
      if (!wdata[HAS_MODE_BIT]) aeoi <= 1'b0;
    end else if (cmd_wr && wdata[OCW3_BIT]) begin
      if (wdata[1]) show_isr <= wdata[0];
    end else if (dat_wr) begin
      case (state)
        CFG_RUN:  mask <= wdata;
        CFG_BASE: begin
          base  <= wdata;
          state <= want_casc ? CFG_CASC : (want_mode ? CFG_MODE : CFG_RUN);
        end
        CFG_CASC: state <= want_mode ? CFG_MODE : CFG_RUN;
        CFG_MODE: begin
          aeoi  <= wdata[AUTO_BIT];
          state <= CFG_RUN;
        end
        default:  state <= CFG_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= addr ? mask : (show_isr ? isr : irr);
  end

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    (dat_wr && state == CFG_RUN) |=> (mask == $past(wdata))); // R2
  AST_INIT_ENTER: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && wdata[START_BIT]) |=> (state == CFG_BASE)); // R3
  AST_INIT_KEEPS_MASK: assert property (@(posedge clk) disable iff (rst)
    (state != CFG_RUN) |=> (mask == $past(mask))); // R3
endmodule

// File: rtl/pic_core.sv
module pic_core #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  irq_in,
  input  logic [N-1:0]  mask,
  input  logic [N-1:0]  base,
  input  logic          aeoi,
  input  logic          init_pulse,
  input  logic          eoi_line_v,
  input  logic [IW-1:0] eoi_line,
  input  logic          eoi_any_v,
  input  logic          ack,
  output logic [N-1:0]  irr,
  output logic [N-1:0]  isr,
  output logic          int_out,
  output logic [N-1:0]  vec_out,
  output logic          vec_valid
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};
  localparam logic [IW-1:0] SPUR_LINE = IW'(N - 1);

  logic [N-1:0]  irq_prev, pend, set_v, clr_eoi, clr_auto;
  logic          p_f, i_f, elig, phase, ack1, ack2, sel_spur;
  logic [IW-1:0] p_idx, i_idx, sel_lvl;

  assign pend = irr & ~mask;

  pic_prio #(.N(N), .IW(IW)) u_pend (.req(pend), .found(p_f), .idx(p_idx));
  pic_prio #(.N(N), .IW(IW)) u_isr  (.req(isr),  .found(i_f), .idx(i_idx));

  assign elig = p_f && (!i_f || (p_idx < i_idx));
  assign ack1 = ack && !phase;
  assign ack2 = ack && phase;

  always_comb begin
    set_v    = (ack1 && elig) ? (ONE << p_idx) : '0;
    clr_eoi  = '0;
    if (eoi_line_v) clr_eoi = clr_eoi | (ONE << eoi_line);
    if (eoi_any_v && i_f) clr_eoi = clr_eoi | (ONE << i_idx);
    clr_auto = (ack2 && aeoi && !sel_spur) ? (ONE << sel_lvl) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_prev <= '0;
      irr      <= '0;
      isr      <= '0;
      phase    <= 1'b0;
      sel_lvl  <= '0;
      sel_spur <= 1'b0;
      int_out  <= 1'b0;
      vec_out  <= '0;
      vec_valid <= 1'b0;
    end else begin
      irq_prev <= irq_in;
      if (init_pulse) begin
        irr       <= '0;
        isr       <= '0;
        phase     <= 1'b0;
        int_out   <= 1'b0;
        vec_valid <= 1'b0;
      end else begin
        irr       <= ((irr | (irq_in & ~irq_prev)) & irq_in) & ~set_v;
        isr       <= (isr & ~clr_eoi & ~clr_auto) | set_v;
        int_out   <= elig;
        vec_valid <= ack2;
        if (ack) phase <= !phase;
        if (ack1) begin
          sel_lvl  <= elig ? p_idx : SPUR_LINE;
          sel_spur <= !elig;
        end
        if (ack2) vec_out <= base + N'(sel_lvl);
      end
    end
  end

  AST_GRANT_SETS_ISR: assert property (@(posedge clk) disable iff (rst)
    (ack1 && elig && !init_pulse) |=> isr[$past(p_idx)]); // R6
  AST_SPUR_NO_ISR: assert property (@(posedge clk) disable iff (rst)
    (ack1 && !elig && !eoi_line_v && !eoi_any_v && !init_pulse) |=> (isr == $past(isr))); // R12
  AST_VEC_AFTER_ACK2: assert property (@(posedge clk) disable iff (rst)
    (ack2 && !init_pulse) |=> vec_valid); // R4
  AST_LINE_EOI_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (eoi_line_v && !ack1) |=> !isr[$past(eoi_line)]); // R9
  AST_INT_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    $rose(int_out) |-> $past((irr & ~mask) != '0)); // R7
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N_IN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic            bus_addr,
  input  logic [N_IN-1:0] bus_wdata,
  output logic [N_IN-1:0] bus_rdata,
  input  logic [N_IN-1:0] irq_in,
  output logic            int_out,
  input  logic            ack,
  output logic [N_IN-1:0] vec_out,
  output logic            vec_valid
);
  localparam int IW = $clog2(N_IN);

  logic [N_IN-1:0] irr, isr, mask, base;
  logic            aeoi, init_pulse, eoi_line_v, eoi_any_v;
  logic [IW-1:0]   eoi_line;

  pic_regif #(.N(N_IN), .IW(IW)) u_regif (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .irr(irr), .isr(isr), .rdata(bus_rdata), .mask(mask),
    .base(base), .aeoi(aeoi), .init_pulse(init_pulse), .eoi_line_v(eoi_line_v),
    .eoi_line(eoi_line), .eoi_any_v(eoi_any_v)
  );

  pic_core #(.N(N_IN), .IW(IW)) u_core (
    .clk(clk), .rst(rst), .irq_in(irq_in), .mask(mask), .base(base),
    .aeoi(aeoi), .init_pulse(init_pulse), .eoi_line_v(eoi_line_v),
    .eoi_line(eoi_line), .eoi_any_v(eoi_any_v), .ack(ack), .irr(irr),
    .isr(isr), .int_out(int_out), .vec_out(vec_out), .vec_valid(vec_valid)
  );
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  logic       clk = 1'b0, rst = 1'b1;
  logic       bwr = 1'b0, brd = 1'b0, badr = 1'b0, ack = 1'b0;
  logic [7:0] bwd = '0, irq = '0;
  logic [7:0] brdata, vec_out;
  logic       int_out, vec_valid;
  int         n_chk = 0, n_err = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_wr(bwr), .bus_rd(brd), .bus_addr(badr),
    .bus_wdata(bwd), .bus_rdata(brdata), .irq_in(irq), .int_out(int_out),
    .ack(ack), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  // {is_read, addr, data, expected}
  localparam int NT = 14;
  localparam logic [17:0] TBL [NT] = '{
    {1'b0, 1'b0, 8'h11, 8'h00}, {1'b0, 1'b1, 8'h20, 8'h00},
    {1'b0, 1'b1, 8'h04, 8'h00}, {1'b0, 1'b1, 8'h01, 8'h00},
    {1'b1, 1'b1, 8'h00, 8'hFF}, {1'b0, 1'b1, 8'h00, 8'h00},
    {1'b1, 1'b1, 8'h00, 8'h00}, {1'b0, 1'b1, 8'hA5, 8'h00},
    {1'b1, 1'b1, 8'h00, 8'hA5}, {1'b0, 1'b1, 8'h00, 8'h00},
    {1'b0, 1'b0, 8'h0B, 8'h00}, {1'b1, 1'b0, 8'h00, 8'h00},
    {1'b0, 1'b0, 8'h0A, 8'h00}, {1'b1, 1'b0, 8'h00, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); bwr = 1'b1; badr = a; bwd = d;
    @(negedge clk); bwr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); brd = 1'b1; badr = a;
    @(negedge clk); brd = 1'b0; d = brdata;
  endtask

  task automatic rd_isr(output logic [7:0] d);
    wr(1'b0, 8'h0B); rd(1'b0, d);
  endtask

  task automatic rd_irr(output logic [7:0] d);
    wr(1'b0, 8'h0A); rd(1'b0, d);
  endtask

  task automatic line(input int n, input logic v);
    @(negedge clk); irq[n] = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_ack(input logic with_wr, input logic [7:0] d,
                        output logic [7:0] v, output logic ok);
    @(negedge clk); ack = 1'b1;
    if (with_wr) begin bwr = 1'b1; badr = 1'b0; bwd = d; end
    @(negedge clk); ack = 1'b0; bwr = 1'b0;
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0; v = vec_out; ok = vec_valid;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] r, v;
    logic ok;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 int_out", {7'd0, int_out}, 8'h00);
    chk("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
    rd(1'b1, r); chk("R1 mask", r, 8'hFF);
    rd(1'b0, r); chk("R1 request", r, 8'h00);
    rd_isr(r);   chk("R1 in-service", r, 8'h00);
    wr(1'b0, 8'h0A);

    for (int i = 0; i < NT; i++) begin
      if (TBL[i][17]) begin
        rd(TBL[i][16], r);
        chk($sformatf("table step %0d (R2/R3/R8)", i), r, TBL[i][7:0]);
      end else begin
        wr(TBL[i][16], TBL[i][15:8]);
      end
    end

    // R5/R6 priority, grant and nesting
    @(negedge clk); irq[4] = 1'b1; irq[6] = 1'b1;
    repeat (3) @(negedge clk);
    rd_irr(r); chk("R5 latch two lines", r, 8'h50);
    chk("R6 int raised", {7'd0, int_out}, 8'h01);
    do_ack(1'b0, 8'h00, v, ok);
    chk("R4 strobe", {7'd0, ok}, 8'h01);
    chk("R4 R6 vector line 4", v, 8'h24);
    rd_isr(r); chk("R6 in-service 4", r, 8'h10);
    rd_irr(r); chk("R5 cleared on grant", r, 8'h40);
    chk("R6 lower blocked", {7'd0, int_out}, 8'h00);
    line(1, 1'b1);
    chk("R6 higher nests", {7'd0, int_out}, 8'h01);
    do_ack(1'b0, 8'h00, v, ok);
    chk("R6 vector line 1", v, 8'h21);
    rd_isr(r); chk("R6 nested in-service", r, 8'h12);
    wr(1'b0, 8'h20);
    rd_isr(r); chk("R10 clears highest", r, 8'h10);
    wr(1'b0, 8'h64);
    rd_isr(r); chk("R9 specific line 4", r, 8'h00);
    repeat (2) @(negedge clk);
    chk("R6 line 6 now eligible", {7'd0, int_out}, 8'h01);
    do_ack(1'b0, 8'h00, v, ok);
    chk("R4 vector line 6", v, 8'h26);
    wr(1'b0, 8'h66);
    rd_isr(r); chk("R9 specific line 6", r, 8'h00);
    @(negedge clk); irq = '0;
    repeat (3) @(negedge clk);

    // R7 masked line
    wr(1'b1, 8'h08);
    line(3, 1'b1);
    chk("R7 masked no int", {7'd0, int_out}, 8'h00);
    rd_irr(r); chk("R7 masked still latched", r, 8'h08);
    line(3, 1'b0);
    rd_irr(r); chk("R5 cleared on drop", r, 8'h00);
    wr(1'b1, 8'h00);

    // R12 spurious
    line(2, 1'b1);
    chk("R12 int before withdraw", {7'd0, int_out}, 8'h01);
    line(2, 1'b0);
    do_ack(1'b0, 8'h00, v, ok);
    chk("R12 spurious vector", v, 8'h27);
    rd_isr(r); chk("R12 no in-service", r, 8'h00);
    wr(1'b1, 8'hFF);
    do_ack(1'b0, 8'h00, v, ok);
    chk("R12 spurious with line 7 masked", v, 8'h27);
    rd_isr(r); chk("R12 masked no in-service", r, 8'h00);
    wr(1'b1, 8'h00);

    // R8 persistence and R13 same-cycle EOI and grant
    line(5, 1'b1);
    do_ack(1'b0, 8'h00, v, ok);
    chk("R4 vector line 5", v, 8'h25);
    line(3, 1'b1);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); chk("R8 select in-service", r, 8'h20);
    rd(1'b0, r); chk("R8 selection persists", r, 8'h20);
    do_ack(1'b1, 8'h65, v, ok);
    chk("R13 vector line 3", v, 8'h23);
    rd(1'b0, r); chk("R13 both updates kept", r, 8'h08);
    wr(1'b0, 8'h20);
    rd(1'b0, r); chk("R10 empties", r, 8'h00);
    @(negedge clk); irq = '0;
    repeat (3) @(negedge clk);

    // R11 automatic retirement, new base
    wr(1'b0, 8'h11); wr(1'b1, 8'h28); wr(1'b1, 8'h04); wr(1'b1, 8'h03);
    line(0, 1'b1);
    do_ack(1'b0, 8'h00, v, ok);
    chk("R3 R4 new base vector", v, 8'h28);
    rd_isr(r); chk("R11 auto cleared", r, 8'h00);
    line(0, 1'b0);

    // R3 cascade byte skipped, init clears in-service
    wr(1'b0, 8'h13); wr(1'b1, 8'h30); wr(1'b1, 8'h00); wr(1'b1, 8'h7F);
    rd(1'b1, r); chk("R3 mask after skipped byte", r, 8'h7F);
    line(7, 1'b1);
    do_ack(1'b0, 8'h00, v, ok);
    chk("R3 base 0x30 line 7", v, 8'h37);
    rd_isr(r); chk("R11 no auto after mode 0", r, 8'h80);
    line(7, 1'b0);
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    rd_isr(r); chk("R3 init clears in-service", r, 8'h00);
    rd(1'b1, r); chk("R3 init keeps mask", r, 8'h7F);

    finish_run();
  end
endmodule